// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers per-channel status events from a bank of DMA channels and turns them into one level-sensitive interrupt line and a small register view for the host. Every channel can report four kinds of event. Two are completion kinds: one fires when a whole linked chain has finished, and the other fires each time a single list node finishes. The other two are separate error kinds. Each event arrives as a one-cycle pulse on its channel's bit of the matching input vector.

Each event kind has three registers. The first is a sticky raw latch. The second is an enable mask. The third is a read-only masked view, which is the raw latch ANDed with the mask. A summary register ORs the four masked views together, one bit per channel, and the interrupt output is the OR of the summary. Software reads the summary to find the channels that need service, reads the per-kind views to find the cause, and clears handled events by writing ones to the raw latch. When a channel is stopped, software clears all four of its raw bits. A plain read/write register holds the channel priority setting, where zero means equal priority.

The host port is a simple bus of valid, write, address and write data signals. Read data is registered and appears one cycle after the request.

Top module: `dmairq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every raw latch, mask and the priority register is zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A pulse on bit i of an event input sets bit i of that kind's raw register. The raw registers are at 0x600 (chain done), 0x608 (node done), 0x610 (error class 1) and 0x618 (error class 2). Read bits at or above NCH are zero.
- R3: The mask registers are read/write, one bit per channel: 0x018 (chain done), 0x01C (node done), 0x020 (error 1) and 0x024 (error 2). A mask bit of 1 enables the event and 0 suppresses it, and only the low NCH bits are stored.
- R4: The masked status registers at 0x004, 0x008, 0x00C and 0x010 (same kind order as R2) read as raw AND mask.
- R5: The summary register at 0x000 has bit i set exactly when channel i has any set bit in the four masked status registers.
- R6: `irq_o` is high whenever any summary bit is set, and it stays high until the last unmasked pending event is cleared or masked.
- R7: Writing a 1 to bit i of a raw register clears that bit, and writing a 0 leaves it unchanged.
- R8: When an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R9: An event whose mask bit is 0 is still latched in the raw register without raising `irq_o`. Setting the mask bit later raises the interrupt.
- R10: The priority register at 0x688 stores a full data word, reads back what was written, and resets to 0.
- R11: Reads of unmapped addresses return zero, and writes to the read-only summary and status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done_i | input | NCH | Chain-complete pulses, one bit per channel |
| evt_node_i | input | NCH | Node-complete pulses, one bit per channel |
| evt_err1_i | input | NCH | Error class 1 pulses, one bit per channel |
| evt_err2_i | input | NCH | Error class 2 pulses, one bit per channel |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, registered one cycle after a read |
| irq_o | output | 1 | Level interrupt, OR of the summary |

## Verification
The four event kinds are driven one at a time and then together, on channels at both ends of the index range and in the middle. This separates a kind-to-address mix-up from a wrong channel-to-bit mapping. Mask patterns of all-ones, all-zeros and a sparse value show whether the masked views and the summary really gate on the mask and whether a masked-out event stays latched. One clearing write carries zeros and another carries ones. A clear issued in the same cycle as a new event on the same bit separates a design that loses the event from one that keeps it. Reads of holes in the map and writes to status addresses expose loose address decoding.

// File: rtl/dmairq_pkg.sv
// Shared definitions for the DMA event interrupt aggregator.
// Assumes a fixed 12-bit byte address map; software depends on these offsets.
package dmairq_pkg;

    localparam int ADDR_W  = 12;
    localparam int NUM_CLS = 4;

    // Event kinds, in the order their registers appear in each group
    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_NODE = 2'd1,
        CLS_ERR1 = 2'd2,
        CLS_ERR2 = 2'd3
    } evt_cls_e;

    // What a read selects
    typedef enum logic [2:0] {
        RK_NONE = 3'd0,
        RK_SUM  = 3'd1,
        RK_STAT = 3'd2,
        RK_MASK = 3'd3,
        RK_RAW  = 3'd4,
        RK_PRIO = 3'd5
    } rd_kind_e;

    localparam logic [ADDR_W-1:0] A_SUMMARY   = 12'h000;
    localparam logic [ADDR_W-1:0] A_STAT_BASE = 12'h004;
    localparam logic [ADDR_W-1:0] A_MASK_BASE = 12'h018;
    localparam logic [ADDR_W-1:0] A_RAW_BASE  = 12'h600;
    localparam logic [ADDR_W-1:0] A_PRIO      = 12'h688;
    localparam int STAT_STEP = 4;
    localparam int MASK_STEP = 4;
    localparam int RAW_STEP  = 8;

    function automatic logic [ADDR_W-1:0] stat_addr(input int c);
        return A_STAT_BASE + ADDR_W'(c * STAT_STEP);
    endfunction

    function automatic logic [ADDR_W-1:0] mask_addr(input int c);
        return A_MASK_BASE + ADDR_W'(c * MASK_STEP);
    endfunction

    function automatic logic [ADDR_W-1:0] raw_addr(input int c);
        return A_RAW_BASE + ADDR_W'(c * RAW_STEP);
    endfunction

endpackage

// File: rtl/dmairq_decode.sv
// Address decoder for the aggregator's register port.
// Produces per-kind write strobes and a read selector; purely combinational.
// Assumes one access per cycle and exact full-address matches.
module dmairq_decode
    import dmairq_pkg::*;
(
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [ADDR_W-1:0]    reg_addr,
    output logic [NUM_CLS-1:0]   raw_we,
    output logic [NUM_CLS-1:0]   mask_we,
    output logic                 prio_we,
    output logic                 rd_en,
    output rd_kind_e             rd_kind,
    output logic [1:0]           rd_cls
);

    logic wr_req;
    assign wr_req = reg_valid && reg_write;
    assign rd_en  = reg_valid && !reg_write;

    // Write strobes for the writable registers
    always_comb begin
        raw_we  = '0;
        mask_we = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            raw_we[c]  = wr_req && (reg_addr == raw_addr(c));
            mask_we[c] = wr_req && (reg_addr == mask_addr(c));
        end
        prio_we = wr_req && (reg_addr == A_PRIO);
    end

    // Read selector: which register and which kind
    always_comb begin
        rd_kind = RK_NONE;
        rd_cls  = 2'd0;
        if (reg_addr == A_SUMMARY) rd_kind = RK_SUM;
        if (reg_addr == A_PRIO)    rd_kind = RK_PRIO;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (reg_addr == stat_addr(c)) begin
                rd_kind = RK_STAT;
                rd_cls  = 2'(c);
            end
            if (reg_addr == mask_addr(c)) begin
                rd_kind = RK_MASK;
                rd_cls  = 2'(c);
            end
            if (reg_addr == raw_addr(c)) begin
                rd_kind = RK_RAW;
                rd_cls  = 2'(c);
            end
        end
    end

endmodule

// File: rtl/dmairq_evt_bank.sv
// One event kind: sticky raw latch, enable mask and masked view.
// Assumes event inputs are single-cycle pulses; a new event beats a
// same-cycle write-one-to-clear on the same bit.
module dmairq_evt_bank #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic           clr_we,
    input  logic           mask_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] masked_o
);

    logic [NCH-1:0] raw_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    // Raw latch: clear written ones, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | evt_i;
    end

    // Mask register: plain load on write
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;

endmodule

// File: rtl/dmairq_ctrl.sv
// Top of the DMA event interrupt aggregator.
// Instantiates one bank per event kind, forms the summary and the level
// interrupt, keeps the priority word and serves registered reads.
// Assumes NCH <= DW and a read latency of one cycle.
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_done_i,
    input  logic [NCH-1:0]    evt_node_i,
    input  logic [NCH-1:0]    evt_err1_i,
    input  logic [NCH-1:0]    evt_err2_i,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_o
);

    logic [NUM_CLS-1:0][NCH-1:0] evt_all;
    logic [NUM_CLS-1:0][NCH-1:0] raw_q;
    logic [NUM_CLS-1:0][NCH-1:0] mask_q;
    logic [NUM_CLS-1:0][NCH-1:0] masked;
    logic [NUM_CLS-1:0]          raw_we;
    logic [NUM_CLS-1:0]          mask_we;
    logic                        prio_we;
    logic                        rd_en;
    rd_kind_e                    rd_kind;
    logic [1:0]                  rd_cls;
    logic [NCH-1:0]              summary;
    logic [DW-1:0]               prio_q;
    logic [DW-1:0]               rd_next;
    logic [DW-1:0]               rdata_q;

    assign evt_all[CLS_DONE] = evt_done_i;
    assign evt_all[CLS_NODE] = evt_node_i;
    assign evt_all[CLS_ERR1] = evt_err1_i;
    assign evt_all[CLS_ERR2] = evt_err2_i;

    dmairq_decode u_dec (
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .raw_we    (raw_we),
        .mask_we   (mask_we),
        .prio_we   (prio_we),
        .rd_en     (rd_en),
        .rd_kind   (rd_kind),
        .rd_cls    (rd_cls)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
        dmairq_evt_bank #(.NCH(NCH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_all[c]),
            .clr_we   (raw_we[c]),
            .mask_we  (mask_we[c]),
            .wdata    (reg_wdata[NCH-1:0]),
            .raw_o    (raw_q[c]),
            .mask_o   (mask_q[c]),
            .masked_o (masked[c])
        );
    end

    // Summary: per channel OR across all masked kinds
    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLS; c++) summary |= masked[c];
    end

    assign irq_o = |summary;

    // Priority word: software-owned storage
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '0;
        else if (prio_we) prio_q <= reg_wdata;
    end

    // Read mux: select the addressed register, zero for holes
    always_comb begin
        unique case (rd_kind)
            RK_SUM:  rd_next = DW'(summary);
            RK_STAT: rd_next = DW'(masked[rd_cls]);
            RK_MASK: rd_next = DW'(mask_q[rd_cls]);
            RK_RAW:  rd_next = DW'(raw_q[rd_cls]);
            RK_PRIO: rd_next = prio_q;
            default: rd_next = '0;
        endcase
    end

    // Read data register: captured on each read request
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/dmairq_ctrl_chk.sv
// Property checker for dmairq_ctrl, attached by bind below.
// Observes ports plus the per-kind raw and mask state of the banks.
module dmairq_ctrl_chk
    import dmairq_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CLS-1:0][NCH-1:0] evt_all,
    input logic [NUM_CLS-1:0][NCH-1:0] raw_q,
    input logic [NUM_CLS-1:0][NCH-1:0] mask_q,
    input logic                        reg_valid,
    input logic                        reg_write,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DW-1:0]               reg_wdata,
    input logic [DW-1:0]               prio_q,
    input logic                        irq_o
);

    // R2 and R8: every pulsed bit is set next cycle, even under a clear
    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all != '0) |=> ((raw_q & $past(evt_all)) == $past(evt_all)));

    // R7: no event and no access leaves every raw latch unchanged
    a_r7_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_valid && evt_all == '0) |=> $stable(raw_q));

    // R9: with every mask zero the interrupt stays low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    // R6: interrupt follows the presence of any unmasked raw bit
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((raw_q & mask_q) != '0));

    // R10: a priority write is stored
    a_r10_prio_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == A_PRIO) |=> (prio_q == $past(reg_wdata)));

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        // R7: written ones clear unless an event hits the same bit
        a_r7_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_valid && reg_write && reg_addr == raw_addr(c))
            |=> ((raw_q[c] & $past(reg_wdata[NCH-1:0]) & ~$past(evt_all[c])) == '0));

        // R3: a mask write loads the low channel bits
        a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_valid && reg_write && reg_addr == mask_addr(c))
            |=> (mask_q[c] == $past(reg_wdata[NCH-1:0])));
    end

endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_all   (evt_all),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .prio_q    (prio_q),
    .irq_o     (irq_o)
);

// File: tb/dmairq_ctrl_test.sv
// Directed bench for dmairq_ctrl: one task per scenario, each self-checking.
`timescale 1ns/1ps
module dmairq_ctrl_test;

    localparam int NCH = 16;
    localparam int DW  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  evt_done_i = '0;
    logic [NCH-1:0]  evt_node_i = '0;
    logic [NCH-1:0]  evt_err1_i = '0;
    logic [NCH-1:0]  evt_err2_i = '0;
    logic            reg_valid = 1'b0;
    logic            reg_write = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dmairq_ctrl #(.NCH(NCH), .DW(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_done_i (evt_done_i),
        .evt_node_i (evt_node_i),
        .evt_err1_i (evt_err1_i),
        .evt_err2_i (evt_err2_i),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        reg_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input logic [NCH-1:0] d, input logic [NCH-1:0] n,
                         input logic [NCH-1:0] e1, input logic [NCH-1:0] e2);
        @(negedge clk);
        evt_done_i = d; evt_node_i = n; evt_err1_i = e1; evt_err2_i = e2;
        @(negedge clk);
        evt_done_i = '0; evt_node_i = '0; evt_err1_i = '0; evt_err2_i = '0;
    endtask

    task automatic t_reset();
        expect_reg("R1 summary", 12'h000, 32'h0);
        expect_reg("R1 status", 12'h004, 32'h0);
        expect_reg("R1 raw", 12'h618, 32'h0);
        expect_reg("R1 mask", 12'h018, 32'h0);
        expect_reg("R1 prio", 12'h688, 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_masks();
        reg_wr(12'h018, 32'hFFFF_FFFF);
        reg_wr(12'h01C, 32'h0000_00A5);
        reg_wr(12'h020, 32'hABCD_1234);
        expect_reg("R3 mask done upper bits dropped", 12'h018, 32'h0000_FFFF);
        expect_reg("R3 mask node", 12'h01C, 32'h0000_00A5);
        expect_reg("R3 mask err1", 12'h020, 32'h0000_1234);
        expect_reg("R3 mask err2", 12'h024, 32'h0);
        for (int c = 0; c < 4; c++) reg_wr(12'h018 + 12'(4 * c), 32'h0);
    endtask

    task automatic t_masked_latch();
        pulse(16'h0020, '0, '0, '0);
        expect_reg("R2 raw done ch5", 12'h600, 32'h0000_0020);
        expect_reg("R4 status masked out", 12'h004, 32'h0);
        expect_reg("R5 summary masked out", 12'h000, 32'h0);
        check("R9 irq low while masked", 32'(irq_o), 32'h0);
        reg_wr(12'h018, 32'h0000_0020);
        check("R9 irq after unmask", 32'(irq_o), 32'h1);
        expect_reg("R4 status done", 12'h004, 32'h0000_0020);
        expect_reg("R5 summary ch5", 12'h000, 32'h0000_0020);
    endtask

    task automatic t_classes();
        for (int c = 0; c < 4; c++) reg_wr(12'h018 + 12'(4 * c), 32'h0000_FFFF);
        pulse('0, 16'h0001, 16'h8000, 16'h0020);
        expect_reg("R2 raw node ch0", 12'h608, 32'h0000_0001);
        expect_reg("R2 raw err1 ch15", 12'h610, 32'h0000_8000);
        expect_reg("R2 raw err2 ch5", 12'h618, 32'h0000_0020);
        expect_reg("R4 status err1", 12'h00C, 32'h0000_8000);
        expect_reg("R4 status node", 12'h008, 32'h0000_0001);
        expect_reg("R5 summary all kinds", 12'h000, 32'h0000_8021);
        reg_wr(12'h020, 32'h0);
        expect_reg("R3 mask gates err1 status", 12'h00C, 32'h0);
        expect_reg("R5 summary without err1", 12'h000, 32'h0000_0021);
        reg_wr(12'h020, 32'h0000_FFFF);
    endtask

    task automatic t_clear();
        reg_wr(12'h600, 32'h0);
        expect_reg("R7 zero write keeps bit", 12'h600, 32'h0000_0020);
        reg_wr(12'h600, 32'hFFFF_FFFF);
        expect_reg("R7 one write clears", 12'h600, 32'h0);
        expect_reg("R6 summary still err2 ch5", 12'h000, 32'h0000_8021);
        check("R6 irq held by others", 32'(irq_o), 32'h1);
        reg_wr(12'h608, 32'h0000_0001);
        reg_wr(12'h610, 32'h0000_8000);
        check("R6 irq held by last event", 32'(irq_o), 32'h1);
        reg_wr(12'h618, 32'h0000_0020);
        expect_reg("R7 summary empty", 12'h000, 32'h0);
        check("R6 irq drops", 32'(irq_o), 32'h0);
    endtask

    task automatic t_collision();
        pulse(16'h000C, '0, '0, '0);
        @(negedge clk);
        evt_done_i = 16'h0008;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'h600; reg_wdata = 32'h0000_000C;
        @(negedge clk);
        evt_done_i = '0; reg_valid = 1'b0; reg_write = 1'b0;
        expect_reg("R8 event beats clear", 12'h600, 32'h0000_0008);
        reg_wr(12'h600, 32'h0000_0008);
        expect_reg("R7 cleared after collision", 12'h600, 32'h0);
    endtask

    task automatic t_prio();
        reg_wr(12'h688, 32'hDEAD_BEEF);
        expect_reg("R10 prio readback", 12'h688, 32'hDEAD_BEEF);
        reg_wr(12'h688, 32'h0);
        expect_reg("R10 prio equal", 12'h688, 32'h0);
    endtask

    task automatic t_unmapped();
        expect_reg("R11 hole 0x100", 12'h100, 32'h0);
        expect_reg("R11 hole 0x604", 12'h604, 32'h0);
        pulse('0, 16'h0200, '0, '0);
        reg_wr(12'h008, 32'hFFFF_FFFF);
        reg_wr(12'h000, 32'hFFFF_FFFF);
        expect_reg("R11 status write ignored", 12'h608, 32'h0000_0200);
        expect_reg("R11 summary write ignored", 12'h000, 32'h0000_0200);
        reg_wr(12'h608, 32'h0000_0200);
        check("R6 irq low at end", 32'(irq_o), 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_masked_latch();
        t_classes();
        t_clear();
        t_collision();
        t_prio();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule